// File: doc/BRIEF.md
# Scattered-Field GPIO Register Bank

This block is a memory-mapped controller for fourteen general-purpose pins whose control and status fields are not packed one bit per register. The direction, drive-value and input-sense bits of each pin are placed in one of three 32-bit registers. Two different field layouts are used. The two lowest pins each own a wide 16-bit slice of the first register. The remaining twelve pins each own a 4-bit nibble in the second or the third register.

Software reaches the bank through a simple single-cycle strobe bus. Every write replaces the whole 32-bit word, and there are no byte enables, so changing one pin is a read-modify-write done by software. The block decodes the three register offsets and routes each written field to the pin that owns it. It drives a per-pin output-enable and output value. It brings each pad input through a two-flop synchronizer into the read-only sense fields. A read returns its data one clock after the strobe, with a ready flag.

Top module: `gpio_scatter_bank`

## Requirements
- R1: While reset is asserted and after it is released, every direction and output bit is 0, so `pad_oe` and `pad_out` are all zero and `bus_ready` is low until the first access.
- R2: Pins 0 and 1 live in the register at byte offset 0x818, at base bit 16×pin: drive value at base+0, direction at base+4, sense at base+8.
- R3: Pins 2 to 9 live in the register at offset 0x81C, in the nibble at base bit 4×(pin−2): drive value at base+0, direction at base+1, sense at base+2.
- R4: Pins 10 to 13 live in the register at offset 0x850, in the nibble at base bit 4×(pin−10), with the same nibble layout as in R3.
- R5: A written value appears on `pad_oe` (from the direction bit) and on `pad_out` (from the drive-value bit) after the clock edge that samples the write strobe.
- R6: Sense bits are read-only and writes to them are ignored. A sense bit shows the pad input through two synchronizer flops. A read whose strobe is sampled at the second edge after a pad change still returns the old level, and a later read returns the new level.
- R7: Every bit of the three registers that is not a pin field reads 0, and writing 1 to it has no effect. This covers nibble bit 3 in the two nibble registers, bits 16–31 of the 0x850 register, and all bits of the 0x818 register other than 0, 4, 8, 16, 20 and 24.
- R8: A write to any other offset changes no pin, and a read from any other offset returns 0.
- R9: `bus_ready` is high for exactly one cycle, the cycle after each sampled strobe (read or write). `bus_rdata` holds the read word in that cycle.
- R10: A write replaces all pin fields of the addressed register at once, clearing bits written as 0 as well as setting bits written as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the GPIO window |
| bus_wdata | input | 32 | Write data, whole word |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access completion, one cycle after the strobe |
| pad_in | input | 14 | Asynchronous pad input levels |
| pad_oe | output | 14 | Per-pin output enable (direction bit) |
| pad_out | output | 14 | Per-pin drive value |

## Verification
A write takes effect on `pad_oe` and `pad_out` at the edge that samples its strobe. The bench drives the strobe at a falling edge and checks the pads at the next falling edge. Read data and `bus_ready` also come from the sampling edge and are checked half a cycle later, and one cycle after that the bench confirms that ready has dropped. A pad input change needs two edges before a read can observe it. The bench therefore first issues a read that must still see the old level, then a second read that must see the new one.

// File: rtl/gpio_scatter_pkg.sv
package gpio_scatter_pkg;

  // Which register holds a pin's fields
  typedef enum logic [1:0] {
    BANK_WIDE   = 2'd0,
    BANK_NIB_LO = 2'd1,
    BANK_NIB_HI = 2'd2,
    BANK_NONE   = 2'd3
  } bank_e;

  function automatic bank_e pin_bank(input int pin);
    if (pin < 2)       return BANK_WIDE;
    else if (pin < 10) return BANK_NIB_LO;
    else if (pin < 14) return BANK_NIB_HI;
    else               return BANK_NONE;
  endfunction

  function automatic int pin_base(input int pin);
    case (pin_bank(pin))
      BANK_WIDE:   return pin * 16;
      BANK_NIB_LO: return (pin - 2) * 4;
      BANK_NIB_HI: return (pin - 10) * 4;
      default:     return 0;
    endcase
  endfunction

  function automatic int out_pos(input int pin);
    return pin_base(pin);
  endfunction

  function automatic int dir_pos(input int pin);
    return pin_base(pin) + ((pin_bank(pin) == BANK_WIDE) ? 4 : 1);
  endfunction

  function automatic int sense_pos(input int pin);
    return pin_base(pin) + ((pin_bank(pin) == BANK_WIDE) ? 8 : 2);
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 14,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= async_in;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic d_out,
  input  logic d_dir,
  output logic q_out,
  output logic q_dir
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_out <= 1'b0;
      q_dir <= 1'b0;
    end else if (load) begin
      q_out <= d_out;
      q_dir <= d_dir;
    end
  end
endmodule

// File: rtl/gpio_bus_port.sv
module gpio_bus_port #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int OFS_A  = 'h818,
  parameter int OFS_B  = 'h81C,
  parameter int OFS_C  = 'h850
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] img_a,
  input  logic [DATA_W-1:0] img_b,
  input  logic [DATA_W-1:0] img_c,
  output logic [2:0]        wr_hit,
  output logic              wr_miss,
  output logic              rd_stb,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready
);
  localparam logic [ADDR_W-1:0] A_A = ADDR_W'(OFS_A);
  localparam logic [ADDR_W-1:0] A_B = ADDR_W'(OFS_B);
  localparam logic [ADDR_W-1:0] A_C = ADDR_W'(OFS_C);

  logic [2:0]        hit;
  logic              wr_stb;
  logic [DATA_W-1:0] rd_mux;

  assign hit     = {bus_addr == A_C, bus_addr == A_B, bus_addr == A_A};
  assign wr_stb  = bus_sel & bus_wr;
  assign rd_stb  = bus_sel & ~bus_wr;
  assign wr_hit  = hit & {3{wr_stb}};
  assign wr_miss = wr_stb & ~(|hit);

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      hit[0]:  rd_mux = img_a;
      hit[1]:  rd_mux = img_b;
      hit[2]:  rd_mux = img_c;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_ready <= 1'b0;
    end else begin
      bus_ready <= bus_sel;
      bus_rdata <= rd_stb ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/gpio_scatter_bank.sv
module gpio_scatter_bank
  import gpio_scatter_pkg::*;
#(
  parameter int NUM_PINS    = 14,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int OFS_A       = 'h818,
  parameter int OFS_B       = 'h81C,
  parameter int OFS_C       = 'h850
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_ready,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out
);
  localparam int NBANK = 3;

  // Named internal events, used by the bound checker
  logic [2:0]          wr_hit;
  logic                wr_miss;
  logic                rd_stb;
  logic [NUM_PINS-1:0] sense_q;
  logic [NUM_PINS-1:0] dir_q;
  logic [NUM_PINS-1:0] out_q;
  logic [DATA_W-1:0]   img [NBANK];

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (sense_q)
  );

  gpio_bus_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OFS_A(OFS_A), .OFS_B(OFS_B), .OFS_C(OFS_C)
  ) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .img_a     (img[0]),
    .img_b     (img[1]),
    .img_c     (img[2]),
    .wr_hit    (wr_hit),
    .wr_miss   (wr_miss),
    .rd_stb    (rd_stb),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    localparam bank_e BK = pin_bank(g);
    if (BK != BANK_NONE) begin : g_cell
      gpio_pin_cell u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_hit[int'(BK)]),
        .d_out (bus_wdata[out_pos(g)]),
        .d_dir (bus_wdata[dir_pos(g)]),
        .q_out (out_q[g]),
        .q_dir (dir_q[g])
      );
    end else begin : g_absent
      assign out_q[g] = 1'b0;
      assign dir_q[g] = 1'b0;
    end
  end

  // Assemble the three register images from the per-pin fields
  always_comb begin
    for (int b = 0; b < NBANK; b++) img[b] = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (pin_bank(p) != BANK_NONE) begin
        img[int'(pin_bank(p))][out_pos(p)]   = out_q[p];
        img[int'(pin_bank(p))][dir_pos(p)]   = dir_q[p];
        img[int'(pin_bank(p))][sense_pos(p)] = sense_q[p];
      end
    end
  end

  assign pad_oe  = dir_q;
  assign pad_out = out_q;
endmodule

// File: rtl/gpio_scatter_bank_chk.sv
module gpio_scatter_bank_chk #(
  parameter int NUM_PINS = 14,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int OFS_A    = 'h818,
  parameter int OFS_B    = 'h81C,
  parameter int OFS_C    = 'h850
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                bus_ready,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pad_out,
  input logic                wr_miss,
  input logic                rd_stb
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0 && pad_out == '0 && !bus_ready));

  p_wide_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_A)) |=>
      (pad_oe[0] == $past(bus_wdata[4]) && pad_out[1] == $past(bus_wdata[16])));

  p_nibble_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_B)) |=>
      (pad_oe[2] == $past(bus_wdata[1]) && pad_out[9] == $past(bus_wdata[28])));

  p_hold_without_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> ($stable(pad_oe) && $stable(pad_out)));

  p_high_half_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && bus_addr == ADDR_W'(OFS_C)) |=> (bus_rdata[DATA_W-1:16] == '0));

  p_unmapped_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_miss |=> ($stable(pad_oe) && $stable(pad_out)));

  p_ready_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |=> bus_ready);

  p_ready_only_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> !bus_ready);
endmodule

bind gpio_scatter_bank gpio_scatter_bank_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .OFS_A(OFS_A), .OFS_B(OFS_B), .OFS_C(OFS_C)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_ready (bus_ready),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out),
  .wr_miss   (wr_miss),
  .rd_stb    (rd_stb)
);

// File: tb/sim_gpio_scatter_bank.sv
module sim_gpio_scatter_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic [13:0] pad_in = '0;
  logic [13:0] pad_oe;
  logic [13:0] pad_out;

  int checks = 0;
  int fails  = 0;

  // Bench-side expectation
  logic [13:0] m_dir = '0;
  logic [13:0] m_out = '0;
  logic [13:0] m_pad = '0;

  always #10 clk = ~clk;

  gpio_scatter_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic void m_write(input logic [11:0] a, input logic [31:0] d);
    if (a == 12'h818) begin
      for (int k = 0; k < 2; k++) begin
        m_out[k] = d[16*k];
        m_dir[k] = d[16*k + 4];
      end
    end else if (a == 12'h81C) begin
      for (int k = 2; k < 10; k++) begin
        m_out[k] = d[4*(k-2)];
        m_dir[k] = d[4*(k-2) + 1];
      end
    end else if (a == 12'h850) begin
      for (int k = 10; k < 14; k++) begin
        m_out[k] = d[4*(k-10)];
        m_dir[k] = d[4*(k-10) + 1];
      end
    end
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a, input logic [13:0] pads);
    logic [31:0] v = '0;
    if (a == 12'h818) begin
      for (int k = 0; k < 2; k++)
        v |= ({31'd0, m_out[k]} << (16*k)) | ({31'd0, m_dir[k]} << (16*k + 4))
           | ({31'd0, pads[k]} << (16*k + 8));
    end else if (a == 12'h81C || a == 12'h850) begin
      for (int n = 0; n < 8; n++) begin
        int k = (a == 12'h81C) ? n + 2 : n + 10;
        if (k < 14)
          v |= {28'd0, 1'b0, pads[k], m_dir[k], m_out[k]} << (4*n);
      end
    end
    return v;
  endfunction

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    m_write(a, d);
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic rdy);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
    rdy = bus_ready;
  endtask

  task automatic read_expect(input logic [11:0] a, input string req);
    logic [31:0] d; logic r;
    bus_read(a, d, r);
    chk(r == 1'b1, {req, " ready"}, {31'd0, r}, 32'd1);
    chk(d == m_read(a, m_pad), req, d, m_read(a, m_pad));
  endtask

  task automatic pads_expect(input string req);
    chk(pad_oe == m_dir, {req, " pad_oe"}, {18'd0, pad_oe}, {18'd0, m_dir});
    chk(pad_out == m_out, {req, " pad_out"}, {18'd0, pad_out}, {18'd0, m_out});
  endtask

  task automatic t_reset;
    chk(pad_oe == '0 && pad_out == '0, "R1 pads in reset", {18'd0, pad_oe}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(bus_ready == 1'b0, "R1 ready idle", {31'd0, bus_ready}, 32'd0);
    pads_expect("R1");
    read_expect(12'h818, "R1 reg 818");
    read_expect(12'h81C, "R1 reg 81C");
    read_expect(12'h850, "R1 reg 850");
  endtask

  task automatic t_wide;
    bus_write(12'h818, 32'h0011_0010);   // pin0 dir, pin1 drive+dir
    pads_expect("R2 R5");
    read_expect(12'h818, "R2 readback");
    bus_write(12'h818, 32'hFFFF_FFFF);   // R7: only field bits stick
    pads_expect("R7 R2 all ones");
    read_expect(12'h818, "R7 R2 unused zero");
  endtask

  task automatic t_nib_lo;
    bus_write(12'h81C, 32'h3102_1320);
    pads_expect("R3 R5");
    read_expect(12'h81C, "R3 readback");
    bus_write(12'h81C, 32'hFFFF_FFFF);
    read_expect(12'h81C, "R7 R3 nibble bit3 zero");
    bus_write(12'h81C, 32'h0000_0003);   // R10: whole word replaces
    pads_expect("R10 clear others");
    read_expect(12'h81C, "R10 readback");
  endtask

  task automatic t_nib_hi;
    bus_write(12'h850, 32'hFFFF_2031);
    pads_expect("R4 R5");
    read_expect(12'h850, "R4 R7 readback");
    pads_expect("R4 other banks kept");
  endtask

  task automatic t_sense;
    logic [31:0] d; logic r; logic [13:0] old_pad;
    old_pad = m_pad;
    @(negedge clk); pad_in = 14'h2A5B;
    bus_read(12'h81C, d, r);
    chk(d == m_read(12'h81C, old_pad), "R6 sync lag old level", d, m_read(12'h81C, old_pad));
    m_pad = 14'h2A5B;
    read_expect(12'h81C, "R6 new level");
    read_expect(12'h818, "R6 wide sense");
    read_expect(12'h850, "R6 hi sense");
    bus_write(12'h81C, 32'h4444_4444);  // only sense bits set
    read_expect(12'h81C, "R6 sense write ignored");
    pads_expect("R6 sense write pads");
    @(negedge clk); pad_in = 14'h15A4; m_pad = 14'h15A4;
    repeat (3) @(negedge clk);
    read_expect(12'h818, "R6 second pattern");
  endtask

  task automatic t_unmapped;
    logic [31:0] d; logic r;
    bus_write(12'h818, 32'h0001_0011);
    bus_write(12'h820, 32'hFFFF_FFFF);
    pads_expect("R8 write 820 ignored");
    bus_write(12'h000, 32'hFFFF_FFFF);
    pads_expect("R8 write 000 ignored");
    bus_read(12'h854, d, r);
    chk(d == 32'd0 && r, "R8 read unmapped zero", d, 32'd0);
  endtask

  task automatic t_ready;
    logic [31:0] d; logic r;
    bus_read(12'h818, d, r);
    chk(r == 1'b1, "R9 ready with read", {31'd0, r}, 32'd1);
    @(negedge clk);
    chk(bus_ready == 1'b0, "R9 ready single cycle", {31'd0, bus_ready}, 32'd0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h850; bus_wdata = 32'h0000_0000;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; m_write(12'h850, 32'h0);
    chk(bus_ready == 1'b1, "R9 ready with write", {31'd0, bus_ready}, 32'd1);
    @(negedge clk);
    chk(bus_ready == 1'b0, "R9 ready drops after write", {31'd0, bus_ready}, 32'd0);
    pads_expect("R10 R5 clear hi bank");
  endtask

  initial begin
    t_reset;
    t_wide;
    t_nib_lo;
    t_nib_hi;
    t_sense;
    t_unmapped;
    t_ready;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule